// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block sits between a memory controller and a set of DDR3 devices split into two output sides, A and B. On every rising clock edge it samples the address, bank and command lines and forwards them to both sides. A command is forwarded only when exactly one active chip-select input is low. Otherwise the command outputs keep their last value and the chip-select outputs stay deasserted. A strap input chooses between two chip selects, each copied to side A and side B, and four chip selects, each driven once on side A.

Three configuration inputs change how the block forwards commands. The first drives a complemented copy of the selected address and bank bits on side B, which cuts simultaneous switching. The second turns off the gated outputs while no chip select is asserted; each side has an output-enable signal that stands for its tri-state control. The third stretches a mode-register write over three clocks and pulses the chip select only in the middle clock. Clock-enable and termination lines are registered every cycle and do not depend on chip select.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While `rst_n` is low all outputs take their idle state: every chip-select output high, address and bank zero, `ras_n`/`cas_n`/`we_n` high, clock-enable and termination low, both output enables high.
- R2: With `quad_mode_n` high only `cs_n_in[1:0]` qualify a command and `cs_n_in[3:2]` are ignored. A command with exactly one of them low appears on the next edge, with `a_cs_n[1:0]` and `b_cs_n` both equal to that input pair and `a_cs_n[3:2]` high.
- R3: With `quad_mode_n` low all four `cs_n_in` bits qualify. A forwarded command drives `a_cs_n` equal to `cs_n_in`, and `b_cs_n` stays `2'b11`.
- R4: When no qualifying chip select is low, the chip-select outputs go high and the address, bank and command outputs keep their previous values.
- R5: When more than one qualifying chip select is low, nothing is forwarded: the chip-select outputs go high, the command outputs hold, and the output enables stay high.
- R6: With `float_en` high and no qualifying chip select low, both output enables go low after the next edge. They return high on the edge that forwards a command.
- R7: With `inv_en` high when a command is captured, the side-B address bits 3 to 9, 11 and 13 to 15 and all side-B bank bits are the complement of side A. With `inv_en` low, both sides are identical.
- R8: Address bits 0, 1, 2, 10 and 12 and the `ras_n`, `cas_n`, `we_n` lines are identical on both sides whatever the setting of `inv_en`.
- R9: `a_cke`/`b_cke` and `a_odt`/`b_odt` equal `cke_in` and `odt_in` from the previous edge, whatever the chip selects are.
- R10: With `hold3_en` high, a forwarded mode-register write (`ras_n`, `cas_n`, `we_n` all low, encoded as command `3'b000`) holds its address, bank and command on the outputs for three cycles. The chip-select outputs are asserted only in the second cycle, and the inputs sampled on the two edges after capture are ignored.
- R11: With `hold3_en` low, a mode-register write is forwarded in a single cycle like any other command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_mode_n | input | 1 | High: two chip selects copied to both sides; low: four chip selects |
| inv_en | input | 1 | Complement selected side-B address and bank bits |
| float_en | input | 1 | Disable gated outputs while no chip select is asserted |
| hold3_en | input | 1 | Three-cycle hold for mode-register writes |
| cs_n_in | input | CS_MAX (4) | Active-low chip-select inputs |
| addr_in | input | ADDR_W (16) | Address inputs |
| bank_in | input | BANK_W (3) | Bank inputs |
| ras_n_in | input | 1 | Row strobe, active low |
| cas_n_in | input | 1 | Column strobe, active low |
| we_n_in | input | 1 | Write enable, active low |
| cke_in | input | CKE_W (2) | Clock-enable inputs, not gated |
| odt_in | input | ODT_W (2) | Termination inputs, not gated |
| a_addr | output | ADDR_W | Side-A address |
| a_bank | output | BANK_W | Side-A bank |
| a_ras_n | output | 1 | Side-A row strobe |
| a_cas_n | output | 1 | Side-A column strobe |
| a_we_n | output | 1 | Side-A write enable |
| a_cs_n | output | CS_MAX | Side-A chip selects (upper two unused in two-select mode) |
| a_cke | output | CKE_W | Side-A clock enables |
| a_odt | output | ODT_W | Side-A termination |
| a_oe | output | 1 | Side-A gated-output enable |
| b_addr | output | ADDR_W | Side-B address, optionally partly complemented |
| b_bank | output | BANK_W | Side-B bank, optionally complemented |
| b_ras_n | output | 1 | Side-B row strobe |
| b_cas_n | output | 1 | Side-B column strobe |
| b_we_n | output | 1 | Side-B write enable |
| b_cs_n | output | DUAL_CS (2) | Side-B chip-select copies (two-select mode only) |
| b_cke | output | CKE_W | Side-B clock enables |
| b_odt | output | ODT_W | Side-B termination |
| b_oe | output | 1 | Side-B gated-output enable |

## Verification
The assertions check the cycle-to-cycle rules on every cycle:
- At most one chip-select output is ever low.
- Side-B chip selects copy side A in two-select mode and stay idle in four-select mode.
- Outputs hold when nothing is qualified.
- The output enable drops under float.
- The side-B complement pattern is correct.
- The clock-enable and termination lines follow their inputs.
- The three-phase hold sequence steps correctly.

The bench scenarios show the rest: the reset values, the exact data forwarded under each mode and inversion setting, and that the upper chip selects are ignored in two-select mode. They also show that inputs arriving during a mode-register hold are discarded, and that a held command gives way to the next command on the correct edge.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    // Phase of the mode-register hold sequence
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_TAIL   = 2'd2
    } hold_ph_e;

    // Address bit positions that side B may drive complemented
    function automatic logic addr_bit_flips(input int idx);
        return ((idx >= 3) && (idx <= 9)) || (idx == 11) ||
               ((idx >= 13) && (idx <= 15));
    endfunction

endpackage

// File: rtl/cmdreg_cs_qualify.sv
module cmdreg_cs_qualify #(
    parameter int CS_MAX  = 4,
    parameter int DUAL_CS = 2
) (
    input  logic              quad_mode_n,
    input  logic [CS_MAX-1:0] cs_n_in,
    output logic [CS_MAX-1:0] cs_fwd_n,
    output logic              cs_one,
    output logic              cs_none,
    output logic              cs_multi
);
    localparam int CNT_W = $clog2(CS_MAX + 1);

    logic [CNT_W-1:0]  low_cnt;
    logic [CS_MAX-1:0] eff_n;

    always_comb begin
        eff_n = cs_n_in;
        if (quad_mode_n) begin
            for (int i = DUAL_CS; i < CS_MAX; i++) begin
                eff_n[i] = 1'b1;
            end
        end
        low_cnt = '0;
        for (int i = 0; i < CS_MAX; i++) begin
            low_cnt = low_cnt + CNT_W'(!eff_n[i]);
        end
    end

    assign cs_fwd_n = eff_n;
    assign cs_one   = (low_cnt == CNT_W'(1));
    assign cs_none  = (low_cnt == '0);
    assign cs_multi = (low_cnt > CNT_W'(1));

endmodule

// File: rtl/cmdreg_hold_seq.sv
module cmdreg_hold_seq
    import cmdreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic strobe
);
    typedef struct packed {
        hold_ph_e ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE:   if (launch) seq_d.ph = PH_STROBE;
            PH_STROBE: seq_d.ph = PH_TAIL;
            PH_TAIL:   seq_d.ph = PH_IDLE;
            default:   seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE};
        else        seq_q <= seq_d;
    end

    assign busy   = (seq_q.ph != PH_IDLE);
    assign strobe = (seq_q.ph == PH_STROBE);

    // R10
    strobe_to_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_STROBE) |=> (seq_q.ph == PH_TAIL));

    // R10
    tail_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_TAIL) |=> (seq_q.ph == PH_IDLE));

    // R10
    launch_enters_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> strobe);

endmodule

// File: rtl/cmdreg_side_b.sv
module cmdreg_side_b
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic              inv_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BANK_W-1:0] bank_out
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        if (addr_bit_flips(i)) begin : g_flip
            assign addr_out[i] = addr_in[i] ^ inv_en;
        end else begin : g_keep
            assign addr_out[i] = addr_in[i];
        end
    end

    for (genvar j = 0; j < BANK_W; j++) begin : g_bank
        assign bank_out[j] = bank_in[j] ^ inv_en;
    end

endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int CS_MAX  = 4,
    parameter int DUAL_CS = 2,
    parameter int CKE_W   = 2,
    parameter int ODT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               quad_mode_n,
    input  logic               inv_en,
    input  logic               float_en,
    input  logic               hold3_en,
    input  logic [CS_MAX-1:0]  cs_n_in,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [BANK_W-1:0]  bank_in,
    input  logic               ras_n_in,
    input  logic               cas_n_in,
    input  logic               we_n_in,
    input  logic [CKE_W-1:0]   cke_in,
    input  logic [ODT_W-1:0]   odt_in,
    output logic [ADDR_W-1:0]  a_addr,
    output logic [BANK_W-1:0]  a_bank,
    output logic               a_ras_n,
    output logic               a_cas_n,
    output logic               a_we_n,
    output logic [CS_MAX-1:0]  a_cs_n,
    output logic [CKE_W-1:0]   a_cke,
    output logic [ODT_W-1:0]   a_odt,
    output logic               a_oe,
    output logic [ADDR_W-1:0]  b_addr,
    output logic [BANK_W-1:0]  b_bank,
    output logic               b_ras_n,
    output logic               b_cas_n,
    output logic               b_we_n,
    output logic [DUAL_CS-1:0] b_cs_n,
    output logic [CKE_W-1:0]   b_cke,
    output logic [ODT_W-1:0]   b_odt,
    output logic               b_oe
);
    typedef struct packed {
        logic [ADDR_W-1:0]  a_addr;
        logic [ADDR_W-1:0]  b_addr;
        logic [BANK_W-1:0]  a_bank;
        logic [BANK_W-1:0]  b_bank;
        logic               ras_n;
        logic               cas_n;
        logic               we_n;
        logic [CS_MAX-1:0]  a_cs_n;
        logic [DUAL_CS-1:0] b_cs_n;
        logic [CS_MAX-1:0]  pend_cs_n;
        logic [CKE_W-1:0]   cke;
        logic [ODT_W-1:0]   odt;
        logic               oe;
    } out_reg_t;

    function automatic out_reg_t idle_value();
        out_reg_t v;
        v           = '0;
        v.ras_n     = 1'b1;
        v.cas_n     = 1'b1;
        v.we_n      = 1'b1;
        v.a_cs_n    = '1;
        v.b_cs_n    = '1;
        v.pend_cs_n = '1;
        v.oe        = 1'b1;
        return v;
    endfunction

    function automatic logic [ADDR_W-1:0] flip_mask();
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) m[i] = addr_bit_flips(i);
        return m;
    endfunction

    localparam logic [ADDR_W-1:0] FLIP_MASK = flip_mask();

    out_reg_t          r_d, r_q;
    logic [CS_MAX-1:0] cs_fwd_n;
    logic              cs_one, cs_none, cs_multi;
    logic              seq_busy, seq_strobe, launch, is_mrs;
    logic [ADDR_W-1:0] b_addr_nx;
    logic [BANK_W-1:0] b_bank_nx;

    cmdreg_cs_qualify #(.CS_MAX(CS_MAX), .DUAL_CS(DUAL_CS)) u_qual (
        .quad_mode_n (quad_mode_n),
        .cs_n_in     (cs_n_in),
        .cs_fwd_n    (cs_fwd_n),
        .cs_one      (cs_one),
        .cs_none     (cs_none),
        .cs_multi    (cs_multi)
    );

    cmdreg_side_b #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_sideb (
        .inv_en   (inv_en),
        .addr_in  (addr_in),
        .bank_in  (bank_in),
        .addr_out (b_addr_nx),
        .bank_out (b_bank_nx)
    );

    cmdreg_hold_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (seq_busy),
        .strobe (seq_strobe)
    );

    assign is_mrs = !ras_n_in && !cas_n_in && !we_n_in;
    assign launch = hold3_en && is_mrs && cs_one && !seq_busy;

    always_comb begin
        r_d        = r_q;
        r_d.cke    = cke_in;
        r_d.odt    = odt_in;
        r_d.a_cs_n = '1;
        r_d.b_cs_n = '1;
        if (seq_busy) begin
            r_d.oe = 1'b1;
            if (seq_strobe) begin
                r_d.a_cs_n = r_q.pend_cs_n;
                if (quad_mode_n) r_d.b_cs_n = r_q.pend_cs_n[DUAL_CS-1:0];
            end
        end else if (cs_one) begin
            r_d.a_addr = addr_in;
            r_d.b_addr = b_addr_nx;
            r_d.a_bank = bank_in;
            r_d.b_bank = b_bank_nx;
            r_d.ras_n  = ras_n_in;
            r_d.cas_n  = cas_n_in;
            r_d.we_n   = we_n_in;
            r_d.oe     = 1'b1;
            if (launch) begin
                r_d.pend_cs_n = cs_fwd_n;
            end else begin
                r_d.a_cs_n = cs_fwd_n;
                if (quad_mode_n) r_d.b_cs_n = cs_fwd_n[DUAL_CS-1:0];
            end
        end else if (cs_none) begin
            r_d.oe = !float_en;
        end else begin
            r_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= idle_value();
        else        r_q <= r_d;
    end

    assign a_addr  = r_q.a_addr;
    assign a_bank  = r_q.a_bank;
    assign a_ras_n = r_q.ras_n;
    assign a_cas_n = r_q.cas_n;
    assign a_we_n  = r_q.we_n;
    assign a_cs_n  = r_q.a_cs_n;
    assign a_cke   = r_q.cke;
    assign a_odt   = r_q.odt;
    assign a_oe    = r_q.oe;
    assign b_addr  = r_q.b_addr;
    assign b_bank  = r_q.b_bank;
    assign b_ras_n = r_q.ras_n;
    assign b_cas_n = r_q.cas_n;
    assign b_we_n  = r_q.we_n;
    assign b_cs_n  = r_q.b_cs_n;
    assign b_cke   = r_q.cke;
    assign b_odt   = r_q.odt;
    assign b_oe    = r_q.oe;

    // R2
    single_cs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~a_cs_n) <= 1);

    // R2
    dual_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quad_mode_n |=> ((b_cs_n == a_cs_n[DUAL_CS-1:0]) && (&a_cs_n[CS_MAX-1:DUAL_CS])));

    // R3
    quad_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_mode_n |=> (&b_cs_n));

    // R4
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_none && !seq_busy) |=> ($stable(a_addr) && $stable(a_bank) && (&a_cs_n)));

    // R5
    multi_cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_multi && !seq_busy) |=> (a_oe && (&a_cs_n) && $stable(a_addr)));

    // R6
    float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (float_en && cs_none && !seq_busy) |=> (!a_oe && !b_oe));

    // R7
    side_b_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_one && !seq_busy) |=>
            ((a_addr ^ b_addr) == ($past(inv_en) ? FLIP_MASK : '0)) &&
            ((a_bank ^ b_bank) == {BANK_W{$past(inv_en)}}));

    // R9
    cke_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((a_cke == $past(cke_in)) && (b_odt == $past(odt_in))));

    // R10
    hold_strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_strobe |=> ($countones(~a_cs_n) == 1));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> ($stable(a_addr) && $stable(b_addr) && $stable(a_we_n)));

    // R11
    one_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_one && !hold3_en && !seq_busy) |=> ($countones(~a_cs_n) == 1));

endmodule

// File: tb/cs_gated_cmd_reg_tb.sv
`timescale 1ns/1ps
module cs_gated_cmd_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quad_mode_n = 1'b1, inv_en = 1'b0, float_en = 1'b0, hold3_en = 1'b0;
    logic [3:0]  cs_n_in = 4'hF;
    logic [15:0] addr_in = '0;
    logic [2:0]  bank_in = '0;
    logic        ras_n_in = 1'b1, cas_n_in = 1'b1, we_n_in = 1'b1;
    logic [1:0]  cke_in = '0, odt_in = '0;
    logic [15:0] a_addr, b_addr;
    logic [2:0]  a_bank, b_bank;
    logic        a_ras_n, a_cas_n, a_we_n, b_ras_n, b_cas_n, b_we_n;
    logic [3:0]  a_cs_n;
    logic [1:0]  b_cs_n, a_cke, b_cke, a_odt, b_odt;
    logic        a_oe, b_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cs_gated_cmd_reg u_dut (
        .clk(clk), .rst_n(rst_n), .quad_mode_n(quad_mode_n), .inv_en(inv_en),
        .float_en(float_en), .hold3_en(hold3_en), .cs_n_in(cs_n_in),
        .addr_in(addr_in), .bank_in(bank_in), .ras_n_in(ras_n_in),
        .cas_n_in(cas_n_in), .we_n_in(we_n_in), .cke_in(cke_in), .odt_in(odt_in),
        .a_addr(a_addr), .a_bank(a_bank), .a_ras_n(a_ras_n), .a_cas_n(a_cas_n),
        .a_we_n(a_we_n), .a_cs_n(a_cs_n), .a_cke(a_cke), .a_odt(a_odt), .a_oe(a_oe),
        .b_addr(b_addr), .b_bank(b_bank), .b_ras_n(b_ras_n), .b_cas_n(b_cas_n),
        .b_we_n(b_we_n), .b_cs_n(b_cs_n), .b_cke(b_cke), .b_odt(b_odt), .b_oe(b_oe)
    );

    typedef struct packed {
        logic        quad_n;
        logic        inv;
        logic        flt;
        logic [3:0]  cs;
        logic [15:0] addr;
        logic [2:0]  bank;
        logic [2:0]  cmd;     // {ras_n, cas_n, we_n}
        logic [3:0]  e_acs;
        logic [1:0]  e_bcs;
        logic [15:0] e_aaddr;
        logic [15:0] e_baddr;
        logic [2:0]  e_bbank;
        logic [2:0]  e_cmd;
        logic        e_oe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R2 dual select, cs0 forwarded to both sides
        '{1'b1,1'b0,1'b0,4'b1110,16'h1234,3'd5,3'b101,4'b1110,2'b10,16'h1234,16'h1234,3'd5,3'b101,1'b1,4'd2},
        // R7 inversion on side B
        '{1'b1,1'b1,1'b0,4'b1101,16'hFFFF,3'd7,3'b011,4'b1101,2'b01,16'hFFFF,16'h1407,3'd0,3'b011,1'b1,4'd7},
        // R2 upper selects ignored in dual mode (R4 hold)
        '{1'b1,1'b1,1'b0,4'b0011,16'hAAAA,3'd1,3'b000,4'b1111,2'b11,16'hFFFF,16'h1407,3'd0,3'b011,1'b1,4'd2},
        // R6 float while deselected
        '{1'b1,1'b0,1'b1,4'b1111,16'hAAAA,3'd1,3'b000,4'b1111,2'b11,16'hFFFF,16'h1407,3'd0,3'b011,1'b0,4'd6},
        // R5 two selects low
        '{1'b1,1'b0,1'b1,4'b1100,16'h5555,3'd2,3'b111,4'b1111,2'b11,16'hFFFF,16'h1407,3'd0,3'b011,1'b1,4'd5},
        // R3 quad mode, cs3
        '{1'b0,1'b0,1'b0,4'b0111,16'h0F0F,3'd2,3'b110,4'b0111,2'b11,16'h0F0F,16'h0F0F,3'd2,3'b110,1'b1,4'd3},
        // R8 fixed bits unchanged under inversion
        '{1'b0,1'b1,1'b0,4'b1011,16'h0000,3'd0,3'b100,4'b1011,2'b11,16'h0000,16'hEBF8,3'd7,3'b100,1'b1,4'd8},
        // R5 quad multi select
        '{1'b0,1'b0,1'b0,4'b0011,16'h3333,3'd3,3'b001,4'b1111,2'b11,16'h0000,16'hEBF8,3'd7,3'b100,1'b1,4'd5},
        // R6 quad float
        '{1'b0,1'b0,1'b1,4'b1111,16'h3333,3'd3,3'b001,4'b1111,2'b11,16'h0000,16'hEBF8,3'd7,3'b100,1'b0,4'd6},
        // R6 enable returns with a command
        '{1'b0,1'b0,1'b1,4'b1110,16'h8001,3'd1,3'b010,4'b1110,2'b11,16'h8001,16'h8001,3'd1,3'b010,1'b1,4'd6}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic drive(input logic [3:0] cs, input logic [15:0] a, input logic [2:0] b, input logic [2:0] cmd);
        cs_n_in = cs; addr_in = a; bank_in = b;
        {ras_n_in, cas_n_in, we_n_in} = cmd;
    endtask

    task automatic check_idle(input string req);
        chk(req, "a_cs_n", 32'(a_cs_n), 32'hF);
        chk(req, "b_cs_n", 32'(b_cs_n), 32'h3);
        chk(req, "a_addr", 32'(a_addr), 32'h0);
        chk(req, "cmd", 32'({a_ras_n, a_cas_n, a_we_n}), 32'h7);
        chk(req, "cke", 32'({a_cke, b_odt}), 32'h0);
        chk(req, "oe", 32'({a_oe, b_oe}), 32'h3);
    endtask

    initial begin
        #200000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cke_in = 2'b11; odt_in = 2'b11;
        #15;
        check_idle("R1");
        cke_in = 2'b00; odt_in = 2'b00;
        @(posedge clk); #5;
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[k].req);
            quad_mode_n = VECS[k].quad_n;
            inv_en      = VECS[k].inv;
            float_en    = VECS[k].flt;
            hold3_en    = 1'b0;
            drive(VECS[k].cs, VECS[k].addr, VECS[k].bank, VECS[k].cmd);
            tick();
            chk(rq, "a_cs_n", 32'(a_cs_n), 32'(VECS[k].e_acs));
            chk(rq, "b_cs_n", 32'(b_cs_n), 32'(VECS[k].e_bcs));
            chk(rq, "a_addr", 32'(a_addr), 32'(VECS[k].e_aaddr));
            chk(rq, "b_addr", 32'(b_addr), 32'(VECS[k].e_baddr));
            chk(rq, "b_bank", 32'(b_bank), 32'(VECS[k].e_bbank));
            chk(rq, "a_cmd", 32'({a_ras_n, a_cas_n, a_we_n}), 32'(VECS[k].e_cmd));
            chk(rq, "b_cmd", 32'({b_ras_n, b_cas_n, b_we_n}), 32'(VECS[k].e_cmd));
            chk(rq, "oe", 32'({a_oe, b_oe}), VECS[k].e_oe ? 32'h3 : 32'h0);
        end

        // R9: cke/odt pass through while deselected
        float_en = 1'b0; inv_en = 1'b0; quad_mode_n = 1'b1;
        drive(4'hF, 16'h0, 3'd0, 3'b111);
        cke_in = 2'b10; odt_in = 2'b01;
        tick();
        chk("R9", "a_cke", 32'(a_cke), 32'h2);
        chk("R9", "b_cke", 32'(b_cke), 32'h2);
        chk("R9", "a_odt", 32'(a_odt), 32'h1);
        chk("R9", "b_odt", 32'(b_odt), 32'h1);

        // R10: three-cycle mode-register hold, chip select only in the middle
        hold3_en = 1'b1;
        drive(4'b1110, 16'h0420, 3'd2, 3'b000);
        tick();
        chk("R10", "c1 a_cs_n", 32'(a_cs_n), 32'hF);
        chk("R10", "c1 a_addr", 32'(a_addr), 32'h0420);
        chk("R10", "c1 cmd", 32'({a_ras_n, a_cas_n, a_we_n}), 32'h0);
        drive(4'b1101, 16'h1111, 3'd4, 3'b101);
        tick();
        chk("R10", "c2 a_cs_n", 32'(a_cs_n), 32'hE);
        chk("R10", "c2 b_cs_n", 32'(b_cs_n), 32'h2);
        chk("R10", "c2 a_addr", 32'(a_addr), 32'h0420);
        tick();
        chk("R10", "c3 a_cs_n", 32'(a_cs_n), 32'hF);
        chk("R10", "c3 a_bank", 32'(a_bank), 32'h2);
        chk("R10", "c3 cmd", 32'({a_ras_n, a_cas_n, a_we_n}), 32'h0);
        tick();
        chk("R10", "next a_cs_n", 32'(a_cs_n), 32'hD);
        chk("R10", "next a_addr", 32'(a_addr), 32'h1111);

        // R11: single-cycle mode-register write without hold
        hold3_en = 1'b0;
        drive(4'b1110, 16'h0030, 3'd1, 3'b000);
        tick();
        chk("R11", "a_cs_n", 32'(a_cs_n), 32'hE);
        chk("R11", "a_addr", 32'(a_addr), 32'h0030);
        drive(4'hF, 16'h0030, 3'd1, 3'b111);
        tick();
        chk("R11", "after a_cs_n", 32'(a_cs_n), 32'hF);

        // R1: reset reapplied mid-run
        cke_in = 2'b11;
        rst_n = 1'b0;
        #3;
        check_idle("R1");
        #2;
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule